// File: doc/BRIEF.md
# SPI Interrupt Status Logic

This block keeps the interrupt state of a serial peripheral controller. Three event sources (transfer finished, receive word ready, receive overflow) each set a bit in a raw status vector. The vector stays set until software writes ones to a clear register. A masked status vector collects the raw bits whose enables are on, and a single interrupt line is high while any masked bit is set.

The three enables are read from scattered positions of the controller's control word and are remapped onto status bit order. The masked status is sticky. It is refreshed only in cycles with a bus access or an event, and a refresh can add bits but never remove them. Only a clear-register write removes bits. Writes to the read-only status addresses have no effect. Event generation, the bus fabric and the read data mux stay outside the block.

Top module: `spi_irq_status`

## Requirements
- R1: Status bit order in both `ris_o` and `mis_o`: bit 0 is transfer done, bit 1 is receive ready, bit 2 is receive overflow. Bit k of `evt_i` is the event for status bit k.
- R2: A high `evt_i[k]` sets `ris_o[k]` at the next rising clock edge. The bit then stays set until it is cleared.
- R3: Enable remap. `ctrl_i[5]` enables status bit 0, `ctrl_i[4]` enables status bit 1 and `ctrl_i[6]` enables status bit 2. All other control bits have no effect.
- R4: A refresh cycle is any cycle with `rd_en`, `wr_en` or any `evt_i` bit high. In a refresh cycle the masked status is ORed at the clock edge with (enables AND the raw status as updated in that cycle). Turning an enable off later does not remove a masked bit.
- R5: In a cycle with no refresh, `mis_o` keeps its value. Raising an enable alone does not raise the interrupt.
- R6: `irq_o` is high exactly when `mis_o` is nonzero, and it changes at the same clock edge as `mis_o`.
- R7: A write (`wr_en` high) to address 3 clears every raw bit and every masked bit whose `wr_data` bit is 1. Bits written as 0 are left unchanged.
- R8: If an event and a clear hit the same bit in one cycle, the raw bit ends up set. The masked bit is then set only if its enable is on.
- R9: Writes to address 2 (general status), 8 (masked status), 9 (raw status) or any other address except 3 leave `ris_o` unchanged and clear nothing.
- R10: While the synchronous active-high `rst` is sampled high, `ris_o`, `mis_o` and `irq_o` become zero at the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 3 | Event pulses, one per status bit |
| ctrl_i | input | 32 | Controller control word carrying the three enables |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word address of the write |
| wr_data | input | 3 | Write data, low three bits of the bus word |
| rd_en | input | 1 | Register read strobe, used only as a refresh trigger |
| ris_o | output | 3 | Raw interrupt status |
| mis_o | output | 3 | Masked interrupt status |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that `rst` is held for at least one edge before use, and that every strobe and event is a clean one-cycle level at the clock edge. They do not assume that events and clears are exclusive, so the collision case falls inside what they check. The stimulus changes inputs only on the falling edge. It holds each vector for exactly one rising edge and deliberately overlaps events with clears and with read-only writes, so that the one-edge properties are exercised in their corner cases.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int NSRC    = 3;
  localparam int SRC_DONE  = 0;
  localparam int SRC_RXRDY = 1;
  localparam int SRC_OVF   = 2;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_enable_remap.sv
module irq_enable_remap
  import spi_irq_pkg::*;
#(
  parameter int CW = 32,
  parameter int POS_DONE  = 5,
  parameter int POS_RXRDY = 4,
  parameter int POS_OVF   = 6
) (
  input  logic [CW-1:0] ctrl_i,
  output src_vec_t      en_o
);
  localparam int POS [NSRC] = '{POS_DONE, POS_RXRDY, POS_OVF};

  for (genvar k = 0; k < NSRC; k++) begin : g_map
    assign en_o[k] = ctrl_i[POS[k]];
  end

  logic unused_ctrl_bits;
  assign unused_ctrl_bits = ^ctrl_i;
endmodule

// File: rtl/irq_raw_status.sv
module irq_raw_status
  import spi_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  src_vec_t set_i,
  input  src_vec_t clr_i,
  output src_vec_t ris_nxt_o,
  output src_vec_t ris_o
);
  src_vec_t ris_q;

  // set dominates clear
  assign ris_nxt_o = (ris_q & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) ris_q <= '0;
    else     ris_q <= ris_nxt_o;
  end

  assign ris_o = ris_q;

  for (genvar k = 0; k < NSRC; k++) begin : g_chk
    // R2
    set_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      set_i[k] |=> ris_o[k]);
    // R7
    clr_takes_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_i[k] && !set_i[k]) |=> !ris_o[k]);
  end
endmodule

// File: rtl/irq_masked_status.sv
module irq_masked_status
  import spi_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     refresh_i,
  input  src_vec_t en_i,
  input  src_vec_t ris_nxt_i,
  input  src_vec_t clr_i,
  output src_vec_t mis_o,
  output logic     irq_o
);
  src_vec_t mis_q, mis_nxt;
  logic     irq_q;

  always_comb begin
    mis_nxt = mis_q & ~clr_i;
    if (refresh_i) mis_nxt = mis_nxt | (en_i & ris_nxt_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mis_q <= '0;
      irq_q <= 1'b0;
    end else begin
      mis_q <= mis_nxt;
      irq_q <= |mis_nxt;
    end
  end

  assign mis_o = mis_q;
  assign irq_o = irq_q;

  // R5
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!refresh_i && clr_i == '0) |=> $stable(mis_o));
  // R6
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == (mis_o != '0));

  for (genvar k = 0; k < NSRC; k++) begin : g_chk
    // R4
    rise_needs_refresh_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(mis_o[k]) |-> $past(refresh_i) && $past(en_i[k]));
  end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
#(
  parameter int CW = 32,
  parameter int AW = 4,
  parameter int ADDR_CLR = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt_i,
  input  logic [CW-1:0]   ctrl_i,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [NSRC-1:0] wr_data,
  input  logic            rd_en,
  output logic [NSRC-1:0] ris_o,
  output logic [NSRC-1:0] mis_o,
  output logic            irq_o
);
  src_vec_t en, clr, ris_nxt;
  logic     clr_hit, refresh;

  // only the clear register is writable here; status addresses are read-only
  assign clr_hit = wr_en && (wr_addr == AW'(ADDR_CLR));
  assign clr     = clr_hit ? wr_data : '0;
  assign refresh = rd_en | wr_en | (|evt_i);

  irq_enable_remap #(.CW(CW)) u_remap (
    .ctrl_i (ctrl_i),
    .en_o   (en)
  );

  irq_raw_status u_raw (
    .clk       (clk),
    .rst       (rst),
    .set_i     (evt_i),
    .clr_i     (clr),
    .ris_nxt_o (ris_nxt),
    .ris_o     (ris_o)
  );

  irq_masked_status u_mask (
    .clk       (clk),
    .rst       (rst),
    .refresh_i (refresh),
    .en_i      (en),
    .ris_nxt_i (ris_nxt),
    .clr_i     (clr),
    .mis_o     (mis_o),
    .irq_o     (irq_o)
  );

  // R9
  ro_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != AW'(ADDR_CLR) && evt_i == '0) |=> $stable(ris_o));
  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (ris_o == '0 && mis_o == '0 && !irq_o));
endmodule

// File: tb/spi_irq_status_tb.sv
module spi_irq_status_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  evt_i = '0;
  logic [31:0] ctrl_i = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [2:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  ris_o, mis_o;
  logic        irq_o;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  spi_irq_status u_dut (
    .clk(clk), .rst(rst), .evt_i(evt_i), .ctrl_i(ctrl_i), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
    .ris_o(ris_o), .mis_o(mis_o), .irq_o(irq_o)
  );

  // fields: evt, en(status order), wr, addr, wdata, rd, exp ris, exp mis, exp irq
  localparam int NV = 19;
  localparam logic [21:0] VEC [NV] = '{
    {3'b001, 3'b000, 1'b0, 4'd0, 3'b000, 1'b0, 3'b001, 3'b000, 1'b0}, // R1 R2 done sets bit0
    {3'b000, 3'b001, 1'b0, 4'd0, 3'b000, 1'b0, 3'b001, 3'b000, 1'b0}, // R5 enable alone
    {3'b000, 3'b001, 1'b0, 4'd0, 3'b000, 1'b1, 3'b001, 3'b001, 1'b1}, // R4 R3 read refresh
    {3'b000, 3'b000, 1'b0, 4'd0, 3'b000, 1'b0, 3'b001, 3'b001, 1'b1}, // R4 sticky
    {3'b000, 3'b000, 1'b1, 4'd3, 3'b001, 1'b0, 3'b000, 3'b000, 1'b0}, // R7 R6 clear
    {3'b010, 3'b010, 1'b0, 4'd0, 3'b000, 1'b0, 3'b010, 3'b010, 1'b1}, // R3 rxrdy
    {3'b100, 3'b010, 1'b0, 4'd0, 3'b000, 1'b0, 3'b110, 3'b010, 1'b1}, // R1 overflow
    {3'b000, 3'b010, 1'b1, 4'd9, 3'b111, 1'b0, 3'b110, 3'b010, 1'b1}, // R9 raw ro
    {3'b000, 3'b100, 1'b1, 4'd8, 3'b111, 1'b0, 3'b110, 3'b110, 1'b1}, // R9 R3 masked ro
    {3'b000, 3'b000, 1'b1, 4'd3, 3'b010, 1'b0, 3'b100, 3'b100, 1'b1}, // R7 partial
    {3'b100, 3'b000, 1'b1, 4'd3, 3'b100, 1'b0, 3'b100, 3'b000, 1'b0}, // R8 set wins
    {3'b000, 3'b000, 1'b1, 4'd3, 3'b100, 1'b0, 3'b000, 3'b000, 1'b0}, // R7
    {3'b111, 3'b000, 1'b0, 4'd0, 3'b000, 1'b0, 3'b111, 3'b000, 1'b0}, // R2 all
    {3'b000, 3'b111, 1'b1, 4'd2, 3'b111, 1'b0, 3'b111, 3'b111, 1'b1}, // R9 gen status ro
    {3'b000, 3'b000, 1'b1, 4'd5, 3'b111, 1'b0, 3'b111, 3'b111, 1'b1}, // R9 other addr
    {3'b000, 3'b111, 1'b1, 4'd3, 3'b111, 1'b0, 3'b000, 3'b000, 1'b0}, // R7 full clear
    {3'b001, 3'b001, 1'b1, 4'd3, 3'b001, 1'b0, 3'b001, 3'b001, 1'b1}, // R8 enabled
    {3'b000, 3'b000, 1'b1, 4'd3, 3'b000, 1'b0, 3'b001, 3'b001, 1'b1}, // R7 zeros keep
    {3'b000, 3'b000, 1'b1, 4'd3, 3'b001, 1'b0, 3'b000, 3'b000, 1'b0}  // R6 irq drops
  };

  function automatic logic [31:0] ctrl_of(input logic [2:0] en);
    logic [31:0] c = '0;
    c[5] = en[0];
    c[4] = en[1];
    c[6] = en[2];
    return c;
  endfunction

  task automatic check(input string req, input logic [2:0] er, input logic [2:0] em,
                       input logic ei);
    n_vec++;
    if (ris_o !== er || mis_o !== em || irq_o !== ei) begin
      n_bad++;
      $display("FAIL %s: ris=%b mis=%b irq=%b expected ris=%b mis=%b irq=%b",
               req, ris_o, mis_o, irq_o, er, em, ei);
    end
  endtask

  task automatic drive(input logic [2:0] ev, input logic [31:0] ct, input logic w,
                       input logic [3:0] a, input logic [2:0] d, input logic r);
    @(negedge clk);
    evt_i = ev; ctrl_i = ct; wr_en = w; wr_addr = a; wr_data = d; rd_en = r;
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R10 reset", 3'b000, 3'b000, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][21:19], ctrl_of(VEC[i][18:16]), VEC[i][15], VEC[i][14:11],
            VEC[i][10:8], VEC[i][7]);
      check($sformatf("vector %0d", i), VEC[i][6:4], VEC[i][3:1], VEC[i][0]);
    end

    // R3: every control bit except the three enables is ignored
    drive(3'b000, 32'h0, 1'b1, 4'd3, 3'b111, 1'b0);
    drive(3'b111, ~32'h70, 1'b0, 4'd0, 3'b000, 1'b1);
    check("R3 other ctrl bits", 3'b111, 3'b000, 1'b0);
    // R3: overflow enable alone at ctrl bit 6
    drive(3'b000, 32'h40, 1'b0, 4'd0, 3'b000, 1'b1);
    check("R3 bit6 to status2", 3'b111, 3'b100, 1'b1);

    // R10: reset in mid-run clears everything
    @(negedge clk);
    rst = 1'b1;
    evt_i = '0; wr_en = 1'b0; rd_en = 1'b0;
    @(posedge clk);
    #2;
    check("R10 mid-run reset", 3'b000, 3'b000, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    drive(3'b000, 32'h70, 1'b0, 4'd0, 3'b000, 1'b1);
    check("R10 stays clear", 3'b000, 3'b000, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule